// File: doc/BRIEF.md
# Transmit Holding-Empty Interrupt Generator

This block decides when a UART transmitter with a 16-entry transmit FIFO reports itself empty and when it requests service from the CPU. It watches the FIFO occupancy, the CPU's writes to the holding register and reads of the interrupt identification register, the interrupt enable, the FIFO-mode enable and a bit-time tick. From these it produces a transmit-empty status flag, an interrupt request and the identification code that the register file returns to software.

The empty flag is normally held back when a lone character has just drained. In that case the flag is released only after one character time minus the final stop bit, counted in bit ticks. The hold-back is skipped when the FIFO has held two or more characters at once since the previous empty event. It is also skipped for the first empty event after the FIFO-mode enable changes. A rise of the empty flag latches a pending request. That request is cleared by a holding-register write or an identification-register read, and it drives the interrupt output only while the transmit interrupt is enabled.

Top module: `tx_empty_irq`

## Requirements
- R1: After reset the empty flag is 1, the interrupt output is 0 and the identification code is 0x1 (nothing pending).
- R2: In any cycle where the FIFO count is non-zero, the empty flag is 0 from the next clock edge on. The empty flag only rises after a cycle in which the count was 0.
- R3: If the count drops to 0 with no fast-path condition active, the empty flag stays 0 until the bit-tick counter reaches the hold length. The flag then rises on the clock edge that follows.
- R4: If the FIFO count has been 2 or more since the last rise of the empty flag, the flag rises on the first clock edge at which the count is 0.
- R5: The "two or more seen" memory is forgotten each time the empty flag rises, so a later lone character is held back again.
- R6: A change of the FIFO-mode enable makes the next rise of the empty flag immediate. If the flag is already 1 when the enable changes, a request is latched at once.
- R7: A rise of the empty flag latches a pending request. While the request is pending and the interrupt is enabled, the interrupt output is 1 and the identification code is 0x2.
- R8: A holding-register write pulse or an identification-register read pulse clears the pending request at the next edge. A clear beats a rise in the same cycle.
- R9: With the interrupt enable at 0, the empty flag still follows R2 to R6 and the interrupt output is 0. A request latched meanwhile appears on the output once the enable returns to 1.
- R10: The hold length is the character length in bit times minus one, with a minimum of one. Only cycles with the bit tick high advance the hold counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_cnt | input | 5 | Characters currently held in the transmit FIFO (0 to 16) |
| thr_wr | input | 1 | One-cycle pulse on a CPU write to the holding register |
| iir_rd | input | 1 | One-cycle pulse on a CPU read of the identification register |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| fifo_en | input | 1 | FIFO-mode enable |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| char_bits | input | 4 | Character length in bit times, including start, parity and stop bits |
| thre | output | 1 | Transmit-empty status flag |
| irq | output | 1 | Interrupt request, active high |
| iir_id | output | 4 | Identification code: 0x2 when this source requests, otherwise 0x1 |

## Verification
The bench targets the boundary between the held-back and the fast empty paths. If the sticky two-byte memory were never cleared, a lone character after a burst would report empty at once. If it were never set, bursts would wait a full character. It counts bit ticks exactly up to the hold length, so an off-by-one in the limit shows as the flag rising one tick early or late. It also drives a clear pulse in the very cycle the flag rises, toggles the FIFO-mode enable while already empty, and parks a request under a disabled enable. A wrong clear priority, a missed enable-change re-arm, or a request dropped or leaked while disabled each shows up as a mismatch on the interrupt output or the identification code.

// File: rtl/txe_pkg.sv
package txe_pkg;
  localparam int CB_W = 4;
  localparam logic [3:0] IIR_TXE  = 4'h2;
  localparam logic [3:0] IIR_NONE = 4'h1;

  // bit ticks to hold the empty flag: character length minus the last stop bit
  function automatic logic [CB_W-1:0] hold_ticks(input logic [CB_W-1:0] char_bits);
    if (char_bits < CB_W'(2)) return CB_W'(1);
    return char_bits - CB_W'(1);
  endfunction
endpackage

// File: rtl/txe_status.sv
module txe_status
  import txe_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic             fifo_en,
  input  logic             bit_tick,
  input  logic [CB_W-1:0]  char_bits,
  output logic             thre,
  output logic             thre_set,
  output logic             fen_chg
);
  logic            fen_q;
  logic            seen2;
  logic            first_q;
  logic [CB_W-1:0] dly_cnt;
  logic [CB_W-1:0] lim;
  logic            empty;
  logic            fast;
  logic            waiting;
  logic            dly_done;

  assign empty    = (fifo_cnt == '0);
  assign fast     = seen2 | first_q;
  assign lim      = hold_ticks(char_bits);
  assign waiting  = empty & ~thre & ~fast;
  assign dly_done = (dly_cnt >= lim);
  assign fen_chg  = (fifo_en != fen_q);
  assign thre_set = empty & ~thre & (fast | dly_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre    <= 1'b1;
      fen_q   <= 1'b0;
      seen2   <= 1'b0;
      first_q <= 1'b0;
      dly_cnt <= '0;
    end else begin
      fen_q <= fifo_en;
      if (!empty)        thre <= 1'b0;
      else if (thre_set) thre <= 1'b1;

      if (fifo_cnt >= CNT_W'(2)) seen2 <= 1'b1;
      else if (thre_set)         seen2 <= 1'b0;

      if (fen_chg)       first_q <= 1'b1;
      else if (thre_set) first_q <= 1'b0;

      if (!waiting)                    dly_cnt <= '0;
      else if (bit_tick && !dly_done)  dly_cnt <= dly_cnt + CB_W'(1);
    end
  end

  p_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt != '0) |=> !thre);
  p_rise_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thre) |-> $past(empty));
  p_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !thre && seen2) |=> thre);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && dly_cnt < lim) |=> !thre);
endmodule

// File: rtl/txe_irq.sv
module txe_irq
  import txe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       thre,
  input  logic       thre_set,
  input  logic       fen_chg,
  input  logic       thr_wr,
  input  logic       iir_rd,
  input  logic       tx_ie,
  output logic       irq,
  output logic [3:0] iir_id
);
  logic pend;
  logic arm;
  logic clr;

  assign arm    = thre_set | (fen_chg & thre);
  assign clr    = thr_wr | iir_rd;
  assign irq    = pend & tx_ie;
  assign iir_id = irq ? IIR_TXE : IIR_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (clr) pend <= 1'b0;
    else if (arm) pend <= 1'b1;
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr || iir_rd) |=> !pend);
  p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_set && !thr_wr && !iir_rd) |=> pend);
  p_hold_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ie && !thr_wr && !iir_rd && pend) |=> pend);
endmodule

// File: rtl/tx_empty_irq.sv
module tx_empty_irq
  import txe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             tx_ie,
  input  logic             fifo_en,
  input  logic             bit_tick,
  input  logic [CB_W-1:0]  char_bits,
  output logic             thre,
  output logic             irq,
  output logic [3:0]       iir_id
);
  logic thre_set;
  logic fen_chg;

  txe_status #(.CNT_W(CNT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .fifo_en(fifo_en),
    .bit_tick(bit_tick), .char_bits(char_bits),
    .thre(thre), .thre_set(thre_set), .fen_chg(fen_chg)
  );

  txe_irq u_irq (
    .clk(clk), .rst_n(rst_n), .thre(thre), .thre_set(thre_set),
    .fen_chg(fen_chg), .thr_wr(thr_wr), .iir_rd(iir_rd), .tx_ie(tx_ie),
    .irq(irq), .iir_id(iir_id)
  );

  p_irq_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (iir_id == IIR_TXE));
endmodule

// File: tb/tx_empty_irq_bench.sv
module tx_empty_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fifo_cnt = '0;
  logic       thr_wr = 1'b0, iir_rd = 1'b0, tx_ie = 1'b1, fifo_en = 1'b0, bit_tick = 1'b0;
  logic [3:0] char_bits = 4'd10;
  logic       thre, irq;
  logic [3:0] iir_id;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_thre, m_seen2, m_first, m_pend, m_fenq;
  int m_ticks;
  bit n_set, n_fast, n_empty, n_chg, e_irq;
  int n_lim;
  logic [3:0] e_iir;

  tx_empty_irq u_tx_empty_irq (
    .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .tx_ie(tx_ie), .fifo_en(fifo_en), .bit_tick(bit_tick), .char_bits(char_bits),
    .thre(thre), .irq(irq), .iir_id(iir_id)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_thre = 1; m_seen2 = 0; m_first = 0; m_pend = 0; m_fenq = 0; m_ticks = 0;
    end else begin
      n_empty = (fifo_cnt == 0);
      n_fast  = m_seen2 || m_first;
      n_lim   = (char_bits < 2) ? 1 : int'(char_bits) - 1;
      n_set   = n_empty && !m_thre && (n_fast || m_ticks >= n_lim);
      n_chg   = (fifo_en != m_fenq);
      if (thr_wr || iir_rd) m_pend = 0;
      else if (n_set || (n_chg && m_thre)) m_pend = 1;
      if (!n_empty || m_thre || n_fast) m_ticks = 0;
      else if (bit_tick && m_ticks < n_lim) m_ticks = m_ticks + 1;
      if (fifo_cnt >= 2) m_seen2 = 1; else if (n_set) m_seen2 = 0;
      if (n_chg) m_first = 1; else if (n_set) m_first = 0;
      if (!n_empty) m_thre = 0; else if (n_set) m_thre = 1;
      m_fenq = fifo_en;
    end
    #2;
    if (rst_n && !done) begin
      e_irq = m_pend && tx_ie;
      e_iir = e_irq ? 4'h2 : 4'h1;
      checks++;
      if (thre !== m_thre || irq !== e_irq || iir_id !== e_iir) begin
        errors++;
        $display("FAIL %s: thre/irq/iir actual %0b/%0b/%0h expected %0b/%0b/%0h",
                 cur_req, thre, irq, iir_id, m_thre, e_irq, e_iir);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spot(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr_byte;
    thr_wr = 1; fifo_cnt = fifo_cnt + 5'd1; cyc(1); thr_wr = 0;
  endtask

  task automatic rd_iir;
    iir_rd = 1; cyc(1); iir_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; cyc(1); bit_tick = 0; cyc(2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    cur_req = "R1";
    spot("R1 thre", thre, 1'b1); spot("R1 irq", irq, 1'b0); spot("R1 iir", iir_id == 4'h1, 1'b1);

    // R3 delayed empty with a lone character, R2 clear on non-zero count
    cur_req = "R3"; char_bits = 4'd10;
    wr_byte; spot("R2 thre low", thre, 1'b0);
    cyc(3); fifo_cnt = 0; cyc(1);
    ticks(8); spot("R3 still held", thre, 1'b0);
    ticks(1); spot("R3 released", thre, 1'b1);
    cur_req = "R7";
    spot("R7 irq", irq, 1'b1); spot("R7 iir 0x2", iir_id == 4'h2, 1'b1);
    cur_req = "R8"; rd_iir; spot("R8 read clears", irq, 1'b0);

    // R4 fast path after a burst
    cur_req = "R4";
    wr_byte; wr_byte; cyc(2); fifo_cnt = 1; cyc(2); fifo_cnt = 0; cyc(2);
    spot("R4 immediate", thre, 1'b1); rd_iir;

    // R5 sticky memory forgotten
    cur_req = "R5";
    wr_byte; cyc(2); fifo_cnt = 0; cyc(3); spot("R5 held again", thre, 1'b0);
    ticks(9); spot("R5 released", thre, 1'b1); rd_iir;

    // R9 disabled interrupt
    cur_req = "R9"; tx_ie = 0;
    wr_byte; fifo_cnt = 0; ticks(10);
    spot("R9 thre updates", thre, 1'b1); spot("R9 irq gated", irq, 1'b0);
    tx_ie = 1; cyc(1); spot("R9 parked request", irq, 1'b1); rd_iir;

    // R6 FIFO-mode enable change
    cur_req = "R6"; fifo_en = 1; cyc(2); spot("R6 rearm", irq, 1'b1); rd_iir;
    wr_byte; cyc(2); fifo_cnt = 0; cyc(2); spot("R6 immediate", thre, 1'b1); rd_iir;
    wr_byte; cyc(1); fifo_cnt = 0; cyc(3); spot("R6 next held", thre, 1'b0);
    ticks(9); spot("R6 released", thre, 1'b1); rd_iir;

    // R8 clear beats a same-cycle rise
    cur_req = "R8";
    wr_byte; wr_byte; cyc(1);
    fifo_cnt = 0; iir_rd = 1; cyc(1); iir_rd = 0; cyc(1);
    spot("R8 thre set", thre, 1'b1); spot("R8 clear wins", irq, 1'b0);
    wr_byte; cyc(1); spot("R8 write clears", irq, 1'b0); fifo_cnt = 0; ticks(10); rd_iir;

    // R10 minimum hold and tick gating
    cur_req = "R10"; char_bits = 4'd1;
    wr_byte; fifo_cnt = 0; cyc(5); spot("R10 no tick no release", thre, 1'b0);
    ticks(1); spot("R10 one tick", thre, 1'b1); rd_iir;
    char_bits = 4'd7; wr_byte; fifo_cnt = 0; ticks(5); spot("R10 short", thre, 1'b0);
    ticks(1); spot("R10 six ticks", thre, 1'b1);
    cyc(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule